// File: doc/BRIEF.md
# Prescaled Event Timer

This block is an 8-bit up-counter fed through a binary prescaler with a programmable ratio. It counts one of two event sources. The first is an instruction-cycle strobe, produced by dividing the oscillator clock by two or by four. The second is a chosen edge, rising or falling, on an external pin. The pin passes through a two-flop synchronizer in the oscillator domain. A detected edge then becomes a one-cycle event.

The prescaler counter is visible to software, and software can load it. Its meaningful width follows the selected ratio. Several writes clear it: a write to the timer, a write to the ratio, and a watchdog reset. A bypass input sends events straight to the timer. When the timer wraps, it sets a sticky overflow flag.

All writes are single-cycle strobes that share one data bus, `wr_data`. The internal source stops during sleep unless the ADC-wake enable is set.

Top module: `tick_timer`

## Requirements
- R1: While `rst_n` is low, `tmr_q`, `pre_q`, `ratio_q` and `ovf` read zero.
- R2: With the prescaler in use and ratio code n in `ratio_q`, the timer advances by one for every 2^(n+1) source events. Code 0 divides by 2 and code 7 divides by 256.
- R3: `pre_q` reads the prescaler count, and for ratio code n bits above bit n always read 0. A `wr_pre` strobe loads `wr_data` masked to bits n..0.
- R4: The prescaler reads 0 after any `wr_tmr`, any `wr_ratio` or any `wdt_rst` strobe. `wr_ratio` loads `ratio_q` from `wr_data[2:0]`.
- R5: With `src_ext`=0, one event occurs every 2 oscillator clocks when `osc_div4`=0 and every 4 when `osc_div4`=1. The first event falls on the 2nd (or 4th) rising clock edge after reset is released.
- R6: With `src_ext`=0, no events occur while `sleep`=1 and `adc_wake_en`=0. Events continue during sleep when `adc_wake_en`=1.
- R7: With `src_ext`=1, one event occurs per rising pin edge when `ext_fall`=0, or per falling edge when `ext_fall`=1. A pin change is counted into the timer on the third rising clock edge after it.
- R8: With `pre_bypass`=1, every source event increments the timer and the prescaler holds its value.
- R9: A wrap of the timer from 0xFF to 0x00 sets `ovf`. `ovf` stays set until an `ovf_clr` strobe clears it. A wrap in the same cycle as `ovf_clr` wins.
- R10: A `wr_tmr` strobe loads `tmr_q` from `wr_data` on the next edge, and a count tick in the same cycle is dropped.
- R11: When a clearing write coincides with `wr_pre`, the prescaler reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low power-on/external reset |
| wdt_rst | input | 1 | Synchronous watchdog-timeout strobe; clears prescaler |
| osc_div4 | input | 1 | Instruction cycle = osc/4 when 1, osc/2 when 0 |
| src_ext | input | 1 | 1 selects the external pin as event source |
| ext_fall | input | 1 | 1 counts falling pin edges, 0 rising |
| ext_pin | input | 1 | Asynchronous external count input |
| pre_bypass | input | 1 | 1 routes events directly to the timer |
| sleep | input | 1 | Sleep state of the core |
| adc_wake_en | input | 1 | Keeps the internal source running during sleep |
| wr_tmr | input | 1 | Write strobe for the timer value |
| wr_ratio | input | 1 | Write strobe for the ratio code |
| wr_pre | input | 1 | Write strobe for the prescaler counter |
| ovf_clr | input | 1 | Clear strobe for the overflow flag |
| wr_data | input | 8 | Write data shared by all write strobes |
| tmr_q | output | 8 | Timer value |
| pre_q | output | 8 | Prescaler counter value |
| ratio_q | output | 3 | Current ratio code |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The assertions assume that every control input other than `ext_pin` is synchronous to `clk` and free of unknown values once reset is released. They also assume that `wdt_rst` and the write strobes are treated as one-cycle events. The pin, by contrast, may change at any negative clock edge with any pulse width, because the bench reference tracks the synchronizer exactly. The stimulus drives all inputs only at falling clock edges. It biases written timer values toward 0xFE and 0xFF so that wraps, and their collisions with `ovf_clr` and `wr_tmr`, happen often.

// File: rtl/tick_timer.sv
`timescale 1ns/1ps
module tick_timer #(
  parameter int W  = 8,
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wdt_rst,
  input  logic          osc_div4,
  input  logic          src_ext,
  input  logic          ext_fall,
  input  logic          ext_pin,
  input  logic          pre_bypass,
  input  logic          sleep,
  input  logic          adc_wake_en,
  input  logic          wr_tmr,
  input  logic          wr_ratio,
  input  logic          wr_pre,
  input  logic          ovf_clr,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  tmr_q,
  output logic [W-1:0]  pre_q,
  output logic [RW-1:0] ratio_q,
  output logic          ovf
);

  localparam logic [W-1:0] ALL1 = {W{1'b1}};

  logic [1:0]   osc_cnt;
  logic [2:0]   pin_sync;
  logic [W-1:0] pre;
  logic [W-1:0] mask;
  logic         cyc_en, int_ev, ext_ev, ev, tick, pre_top, pre_clr;

  // instruction-cycle strobe
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) osc_cnt <= '0;
    else        osc_cnt <= osc_cnt + 2'd1;

  assign cyc_en = osc_div4 ? (osc_cnt == 2'd3) : osc_cnt[0];
  assign int_ev = cyc_en & (~sleep | adc_wake_en);

  // pin synchronizer and edge detect
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pin_sync <= '0;
    else        pin_sync <= {pin_sync[1:0], ext_pin};

  assign ext_ev = ext_fall ? (pin_sync[2] & ~pin_sync[1])
                           : (~pin_sync[2] & pin_sync[1]);
  assign ev     = src_ext ? ext_ev : int_ev;

  // prescaler
  assign mask    = ~((ALL1 << ratio_q) << 1);
  assign pre_top = (pre == mask);
  assign tick    = ev & (pre_bypass | pre_top);
  assign pre_clr = wr_tmr | wr_ratio | wdt_rst;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  pre <= '0;
    else if (pre_clr)            pre <= '0;
    else if (wr_pre)             pre <= wr_data & mask;
    else if (ev && !pre_bypass)  pre <= pre_top ? '0 : pre + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        ratio_q <= '0;
    else if (wr_ratio) ratio_q <= wr_data[RW-1:0];

  // timer and overflow flag
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      tmr_q <= '0;
    else if (wr_tmr) tmr_q <= wr_data;
    else if (tick)   tmr_q <= tmr_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                   ovf <= 1'b0;
    else if (tick && !wr_tmr && tmr_q == ALL1)    ovf <= 1'b1;
    else if (ovf_clr)                             ovf <= 1'b0;

  assign pre_q = pre;

  p_pre_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_q & ~mask) == '0);

  p_clear_pre_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tmr || wr_ratio || wdt_rst) |=> pre_q == '0);

  p_tmr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_tmr |=> (tmr_q == $past(tmr_q) || tmr_q == $past(tmr_q) + 1'b1));

  p_wr_tmr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tmr |=> tmr_q == $past(wr_data));

  p_sleep_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_ext && sleep && !adc_wake_en && !wr_tmr) |=> $stable(tmr_q));

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf);

  p_bypass_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_bypass && !wr_tmr && !wr_ratio && !wdt_rst && !wr_pre) |=> $stable(pre_q));

endmodule

// File: tb/tick_timer_bench.sv
`timescale 1ns/1ps
module tick_timer_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wdt_rst = 0, osc_div4 = 0, src_ext = 0, ext_fall = 0, ext_pin = 0;
  logic pre_bypass = 1, sleep = 0, adc_wake_en = 0;
  logic wr_tmr = 0, wr_ratio = 0, wr_pre = 0, ovf_clr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] tmr_q, pre_q;
  logic [2:0] ratio_q;
  logic ovf;

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 0, done = 0;

  always #4 clk = ~clk;

  tick_timer u_tick_timer (.*);

  // reference state
  int m_k = 0, m_s1 = 0, m_s2 = 0, m_sp = 0, m_pre = 0, m_tmr = 0, m_ratio = 0, m_ovf = 0;

  function automatic int divisor(int code);
    return 1 << (code + 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_k = 0; m_s1 = 0; m_s2 = 0; m_sp = 0; m_pre = 0; m_tmr = 0; m_ratio = 0; m_ovf = 0;
    end else begin
      int cyc, ie, ee, ev, dv, tk, wrap;
      cyc = osc_div4 ? (m_k == 3) : (m_k % 2 == 1);
      m_k = (m_k + 1) % 4;
      ie = cyc && (!sleep || adc_wake_en);
      ee = ext_fall ? (m_sp && !m_s2) : (!m_sp && m_s2);
      ev = src_ext ? ee : ie;
      dv = divisor(m_ratio);
      tk = pre_bypass ? ev : (ev && (m_pre + 1 == dv));
      wrap = !wr_tmr && tk && m_tmr == 255;
      if (wr_tmr || wr_ratio || wdt_rst) m_pre = 0;
      else if (wr_pre) m_pre = wr_data % dv;
      else if (ev && !pre_bypass) m_pre = (m_pre + 1) % dv;
      m_tmr = wr_tmr ? int'(wr_data) : (m_tmr + tk) % 256;
      if (wrap) m_ovf = 1; else if (ovf_clr) m_ovf = 0;
      if (wr_ratio) m_ratio = wr_data[2:0];
      m_sp = m_s2; m_s2 = m_s1; m_s1 = ext_pin;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    chk("R2 timer vs reference", tmr_q, m_tmr);
    chk("R3 prescaler vs reference", pre_q, m_pre);
    chk("R4 ratio vs reference", ratio_q, m_ratio);
    chk("R9 overflow vs reference", ovf, m_ovf);
  end

  task automatic restart(bit div4, bit ext, bit byp, bit slp, bit adc);
    @(negedge clk); rst_n = 0;
    osc_div4 = div4; src_ext = ext; pre_bypass = byp; sleep = slp; adc_wake_en = adc;
    ext_fall = 0; ext_pin = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic run_check(int n, int exp_t, string tag);
    repeat (n) @(posedge clk);
    @(negedge clk);
    chk(tag, tmr_q, exp_t);
  endtask

  task automatic wr(bit t, bit r, bit p, bit w, logic [7:0] d);
    @(negedge clk);
    wr_tmr = t; wr_ratio = r; wr_pre = p; wdt_rst = w; wr_data = d;
    @(negedge clk);
    wr_tmr = 0; wr_ratio = 0; wr_pre = 0; wdt_rst = 0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    chk("R1 tmr in reset", tmr_q, 0);
    chk("R1 pre in reset", pre_q, 0);
    chk("R1 ratio in reset", ratio_q, 0);
    chk("R1 ovf in reset", ovf, 0);
    cmp_on = 1;

    restart(0, 0, 1, 0, 0); run_check(20, 10, "R5 osc/2 events");
    chk("R8 bypass holds prescaler", pre_q, 0);
    restart(1, 0, 1, 0, 0); run_check(20, 5, "R5 osc/4 events");
    restart(0, 0, 1, 1, 0); run_check(20, 0, "R6 sleep halts");
    restart(0, 0, 1, 1, 1); run_check(20, 10, "R6 adc wake keeps running");
    restart(0, 0, 0, 0, 0); run_check(20, 5, "R2 ratio 0 divides by 2");
    run_check(2, 5, "R2 ratio 0 partial");
    chk("R3 prescaler mid count", pre_q, 1);

    restart(0, 1, 1, 0, 0);
    @(negedge clk); ext_pin = 1;
    run_check(2, 0, "R7 not yet after two edges");
    run_check(1, 1, "R7 rising counted on third edge");
    @(negedge clk); ext_pin = 0;
    run_check(4, 1, "R7 falling ignored in rising mode");
    @(negedge clk); ext_fall = 1; ext_pin = 1;
    run_check(4, 1, "R7 rising ignored in falling mode");
    @(negedge clk); ext_pin = 0;
    run_check(4, 2, "R7 falling counted");

    restart(0, 0, 0, 1, 0);
    wr(0, 1, 0, 0, 8'd7);
    chk("R4 ratio loaded", ratio_q, 7);
    wr(0, 0, 1, 0, 8'hA5);
    chk("R3 full width load", pre_q, 8'hA5);
    wr(0, 1, 0, 0, 8'd2);
    chk("R4 ratio write clears prescaler", pre_q, 0);
    wr(0, 0, 1, 0, 8'hFF);
    chk("R3 load masked to ratio 2", pre_q, 8'h07);
    wr(1, 0, 0, 0, 8'h10);
    chk("R10 timer loaded", tmr_q, 8'h10);
    chk("R4 timer write clears prescaler", pre_q, 0);
    wr(0, 0, 1, 0, 8'h05);
    wr(0, 0, 0, 1, 8'h00);
    chk("R4 watchdog clears prescaler", pre_q, 0);
    wr(1, 0, 1, 0, 8'h03);
    chk("R11 clear beats load", pre_q, 0);

    wr(1, 0, 0, 0, 8'hFF);
    @(negedge clk); pre_bypass = 1; sleep = 0;
    repeat (4) @(posedge clk); @(negedge clk);
    chk("R9 wrap sets flag", ovf, 1);
    sleep = 1;
    repeat (3) @(negedge clk);
    chk("R9 flag sticky", ovf, 1);
    ovf_clr = 1; @(negedge clk); ovf_clr = 0;
    chk("R9 clear strobe", ovf, 0);

    restart(0, 0, 0, 0, 0);
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      wr_tmr   = ($urandom % 100) < 5;
      wr_ratio = ($urandom % 100) < 4;
      wr_pre   = ($urandom % 100) < 5;
      wdt_rst  = ($urandom % 100) < 2;
      ovf_clr  = ($urandom % 100) < 6;
      wr_data  = (($urandom % 4) == 0) ? 8'hFE + 8'($urandom % 2) : 8'($urandom);
      if (wr_ratio && ($urandom % 2)) wr_data[2:0] = 3'($urandom % 2);
      if (($urandom % 100) < 30) ext_pin = ~ext_pin;
      if (($urandom % 100) < 3) sleep = ~sleep;
      if (($urandom % 100) < 2) adc_wake_en = ~adc_wake_en;
      if (($urandom % 100) < 2) src_ext = ~src_ext;
      if (($urandom % 100) < 2) pre_bypass = ~pre_bypass;
      if (($urandom % 100) < 1) osc_div4 = ~osc_div4;
      if (($urandom % 100) < 1) ext_fall = ~ext_fall;
    end
    @(negedge clk);
    wr_tmr = 0; wr_ratio = 0; wr_pre = 0; wdt_rst = 0; ovf_clr = 0;
    rst_n = 0;
    @(negedge clk);
    chk("R1 tmr after reset", tmr_q, 0);
    chk("R1 ovf after reset", ovf, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial void'($urandom(32'd1357));
endmodule